// File: doc/BRIEF.md
# Overlap-save segment buffer controller

This block gathers complex baseband samples for one radar pulse into a buffer that holds exactly one transform frame. A long pulse is cut into overlapping segments. The tail of each segment is carried into the head of the next one, so a downstream fast-convolution engine can discard the wrapped part of its result. A short pulse, or the final partial segment of a long one, is completed with zeros up to the frame size.

For every frame position the block fetches one reference sample from an external memory. It uses a request/ready handshake, and the address is tagged with the segment number. The block then hands the buffered sample and its reference to the processor as one pair. It waits until the processor has returned a full frame of results and forwards those results on its output port. Only then does it move to the next segment.

The controller is blocking. Samples are taken only while it is collecting. A pulse starts only when the trigger goes from low to high while the block is idle.

Top module: `ovs_segment_ctrl`

## Requirements
- R1: After reset the status output reads 0 (idle), the segment index reads 0, and the memory request, processor-valid and output-valid strobes are all low.
- R2: A pulse starts only on a low-to-high transition of the trigger seen while idle. Valid samples presented while idle change nothing. A trigger held high after a pulse completes does not start a new one.
- R3: Each 18-bit signed input is stored as 16 bits by adding 2, shifting right arithmetically by 2 and saturating to [-32768, 32767]. So 131071 stores as 32767, -131072 as -32768, 1 as 0, 2 as 1, -2 as 0 and -3 as -1.
- R4: With the long select low, a pulse is one segment of 50 samples. Frame positions 50 to 1023 hold zero.
- R5: With the long select high, a pulse is 3000 samples over 4 segments. The first segment takes 1024 new samples, the second and third take 896 each, and the fourth takes the last 184 and holds zero from position 312 to 1023.
- R6: In segments 1 to 3 of a long pulse, frame positions 0 to 127 equal positions 896 to 1023 of the previous segment, and the segment index advances by one between segments.
- R7: The 12-bit reference address is {segment index[1:0], position[9:0]} for a long pulse and {2'b00, position} for a short one. The request stays high with a stable address until ready is seen.
- R8: Pairs go to the processor in position order 0 to 1023. Each pair carries the buffered I and Q sample and the reference real and imaginary values returned for that position.
- R9: The block forwards each processor result on out_i/out_q one cycle after it arrives. It advances past a segment only after 1024 results, and it returns to idle after the last segment.
- R10: The status output encodes 0 idle, 1 collect, 2 zero-pad, 3 wait for reference, 4 pass pair, 5 wait for processor, 6 frame done, 7 overlap copy. No memory request or pair is issued while idle.
- R11: During a long pulse the segment index takes every value 0, 1, 2 and 3 while requesting reference data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 18 | Input sample, in-phase, signed |
| in_q | input | 18 | Input sample, quadrature, signed |
| trig | input | 1 | Pulse trigger, acts on its rising edge |
| long_sel | input | 1 | 1 selects long pulse, 0 short pulse |
| mem_req | output | 1 | Reference fetch request |
| mem_addr | output | 12 | Reference address |
| mem_ready | input | 1 | Reference data valid |
| mem_re | input | 16 | Reference sample, real |
| mem_im | input | 16 | Reference sample, imaginary |
| pr_valid | output | 1 | Pair valid to processor |
| pr_smp_i | output | 16 | Buffered sample, in-phase |
| pr_smp_q | output | 16 | Buffered sample, quadrature |
| pr_ref_re | output | 16 | Reference, real |
| pr_ref_im | output | 16 | Reference, imaginary |
| rs_valid | input | 1 | Processor result strobe |
| rs_i | input | 16 | Processor result, in-phase |
| rs_q | input | 16 | Processor result, quadrature |
| out_valid | output | 1 | Forwarded result strobe |
| out_i | output | 16 | Forwarded result, in-phase |
| out_q | output | 16 | Forwarded result, quadrature |
| seg_idx | output | 2 | Current segment index |
| status | output | 4 | Controller state code |

## Verification
The assertions check the local rules on every cycle. These are the held request with a stable address, that no pair leaves without a preceding ready, that the idle state stays quiet unless the trigger is high, that results are forwarded one cycle later, and that the segment index steps by one on leaving the overlap copy. Frame contents can only be shown by the bench's scenarios. These cover rounding and saturation, the zero-pad regions, the carried overlap, the segment-tagged addresses and the total result count. The bench checks them through an echo processor stub whose outputs expose every buffered sample and reference address.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_COLLECT = 4'd1,
      ST_ZPAD    = 4'd2,
      ST_REF     = 4'd3,
      ST_PASS    = 4'd4,
      ST_DRAIN   = 4'd5,
      ST_DONE    = 4'd6,
      ST_CARRY   = 4'd7
   } ovs_state_t;
endpackage

// File: rtl/ovs_sample_conv.sv
module ovs_sample_conv #(
   parameter int IN_W     = 18,
   parameter int SMP_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [IN_W-1:0]  x,
   output logic [SMP_W-1:0] y
);
   localparam int SHIFT = IN_W - SMP_W;

   if (SHIFT < 1) begin : g_bad_width
      $error("ovs_sample_conv: IN_W must exceed SMP_W");
   end

   if (ROUND_EN) begin : g_round
      localparam logic signed [IN_W:0] HALF = (IN_W+1)'(1) <<< (SHIFT-1);
      localparam logic signed [IN_W:0] VMAX = (IN_W+1)'((1 << (SMP_W-1)) - 1);
      localparam logic signed [IN_W:0] VMIN = -((IN_W+1)'(1) <<< (SMP_W-1));
      logic signed [IN_W:0] sum;
      logic signed [IN_W:0] shs;
      always_comb begin
         sum = $signed({x[IN_W-1], x}) + HALF;
         shs = sum >>> SHIFT;
         if (shs > VMAX)      y = SMP_W'(VMAX);
         else if (shs < VMIN) y = SMP_W'(VMIN);
         else                 y = SMP_W'(shs);
      end
   end else begin : g_trunc
      logic signed [IN_W-1:0] shs;
      always_comb begin
         shs = $signed(x) >>> SHIFT;
         y   = SMP_W'(shs);
      end
   end
endmodule

// File: rtl/ovs_frame_buf.sv
module ovs_frame_buf #(
   parameter int DEPTH = 1024,
   parameter int W     = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata_i,
   input  logic [W-1:0]  wdata_q,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata_i,
   output logic [W-1:0]  rdata_q
);
   logic [W-1:0] mem_i [DEPTH];
   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_i[waddr] <= wdata_i;
         mem_q[waddr] <= wdata_q;
      end
   end

   assign rdata_i = mem_i[raddr];
   assign rdata_q = mem_q[raddr];
endmodule

// File: rtl/ovs_result_track.sv
module ovs_result_track #(
   parameter int FRAME = 1024,
   parameter int W     = 16,
   localparam int CW   = $clog2(FRAME) + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         count_en,
   input  logic         rs_valid,
   input  logic [W-1:0] rs_i,
   input  logic [W-1:0] rs_q,
   output logic         done,
   output logic         out_valid,
   output logic [W-1:0] out_i,
   output logic [W-1:0] out_q
);
   localparam logic [CW-1:0] FULL = CW'(FRAME);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= rs_valid && count_en;
         if (rs_valid && count_en) begin
            out_i <= rs_i;
            out_q <= rs_q;
         end
         if (clr)                         cnt <= '0;
         else if (rs_valid && count_en)   cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == FULL);
endmodule

// File: rtl/ovs_segment_ctrl.sv
module ovs_segment_ctrl
   import ovs_pkg::*;
#(
   parameter int IN_W      = 18,
   parameter int SMP_W     = 16,
   parameter int FRAME     = 1024,
   parameter int OVERLAP   = 128,
   parameter int LONG_SEGS = 4,
   parameter int LONG_LEN  = 3000,
   parameter int SHORT_LEN = 50,
   parameter bit ROUND_EN  = 1'b1,
   localparam int AW       = $clog2(FRAME),
   localparam int SEG_W    = (LONG_SEGS > 1) ? $clog2(LONG_SEGS) : 1,
   localparam int REF_AW   = SEG_W + AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_i,
   input  logic [IN_W-1:0]   in_q,
   input  logic              trig,
   input  logic              long_sel,
   output logic              mem_req,
   output logic [REF_AW-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [SMP_W-1:0]  mem_re,
   input  logic [SMP_W-1:0]  mem_im,
   output logic              pr_valid,
   output logic [SMP_W-1:0]  pr_smp_i,
   output logic [SMP_W-1:0]  pr_smp_q,
   output logic [SMP_W-1:0]  pr_ref_re,
   output logic [SMP_W-1:0]  pr_ref_im,
   input  logic              rs_valid,
   input  logic [SMP_W-1:0]  rs_i,
   input  logic [SMP_W-1:0]  rs_q,
   output logic              out_valid,
   output logic [SMP_W-1:0]  out_i,
   output logic [SMP_W-1:0]  out_q,
   output logic [SEG_W-1:0]  seg_idx,
   output logic [3:0]        status
);
   localparam int ADVANCE  = FRAME - OVERLAP;
   localparam int MAX_LEN  = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);
   localparam logic [AW-1:0]    POS_LAST  = AW'(FRAME - 1);
   localparam logic [AW-1:0]    OVL_LAST  = AW'(OVERLAP - 1);
   localparam logic [AW-1:0]    OVL_START = AW'(OVERLAP);
   localparam logic [AW-1:0]    ADV_BASE  = AW'(ADVANCE);
   localparam logic [CNT_W-1:0] LONG_M1   = CNT_W'(LONG_LEN - 1);
   localparam logic [CNT_W-1:0] SHORT_M1  = CNT_W'(SHORT_LEN - 1);
   localparam logic [SEG_W-1:0] SEG_LAST  = SEG_W'(LONG_SEGS - 1);

   // elaboration-time parameter checks
   if ((1 << AW) != FRAME) begin : g_chk_pow2
      $error("ovs_segment_ctrl: FRAME must be a power of two");
   end
   if (OVERLAP < 1 || OVERLAP >= FRAME) begin : g_chk_ovl
      $error("ovs_segment_ctrl: OVERLAP must lie in 1..FRAME-1");
   end
   if (SHORT_LEN < 1 || SHORT_LEN > FRAME) begin : g_chk_short
      $error("ovs_segment_ctrl: SHORT_LEN must lie in 1..FRAME");
   end
   if (LONG_SEGS < 2 || (1 << SEG_W) != LONG_SEGS) begin : g_chk_segs
      $error("ovs_segment_ctrl: LONG_SEGS must be a power of two of at least 2");
   end
   if (LONG_LEN > FRAME + (LONG_SEGS-1)*ADVANCE ||
       LONG_LEN <= FRAME + (LONG_SEGS-2)*ADVANCE) begin : g_chk_long
      $error("ovs_segment_ctrl: LONG_LEN does not need exactly LONG_SEGS segments");
   end

   ovs_state_t        st;
   logic              trig_d;
   logic              long_q;
   logic [SEG_W-1:0]  seg;
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     idx;
   logic [CNT_W-1:0]  taken;
   logic [SMP_W-1:0]  ref_re_q;
   logic [SMP_W-1:0]  ref_im_q;

   logic              trig_rise;
   logic [CNT_W-1:0]  take_m1;
   logic [SMP_W-1:0]  cv_i, cv_q;
   logic              buf_we;
   logic [AW-1:0]     buf_waddr, buf_raddr;
   logic [SMP_W-1:0]  buf_wi, buf_wq, buf_ri, buf_rq;
   logic              res_clr, res_en, res_done;

   assign trig_rise = trig && !trig_d;
   assign take_m1   = long_q ? LONG_M1 : SHORT_M1;

   ovs_sample_conv #(.IN_W(IN_W), .SMP_W(SMP_W), .ROUND_EN(ROUND_EN)) u_conv_i (
      .x(in_i), .y(cv_i));
   ovs_sample_conv #(.IN_W(IN_W), .SMP_W(SMP_W), .ROUND_EN(ROUND_EN)) u_conv_q (
      .x(in_q), .y(cv_q));

   // buffer write port: incoming sample, zero fill, or overlap carry
   always_comb begin
      buf_we    = 1'b0;
      buf_waddr = wptr;
      buf_wi    = cv_i;
      buf_wq    = cv_q;
      buf_raddr = idx;
      unique case (st)
         ST_COLLECT: buf_we = in_valid;
         ST_ZPAD: begin
            buf_we = 1'b1;
            buf_wi = '0;
            buf_wq = '0;
         end
         ST_CARRY: begin
            buf_we    = 1'b1;
            buf_waddr = idx;
            buf_raddr = ADV_BASE + idx;
            buf_wi    = buf_ri;
            buf_wq    = buf_rq;
         end
         default: ;
      endcase
   end

   ovs_frame_buf #(.DEPTH(FRAME), .W(SMP_W)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_waddr),
      .wdata_i(buf_wi), .wdata_q(buf_wq),
      .raddr(buf_raddr), .rdata_i(buf_ri), .rdata_q(buf_rq));

   assign res_en  = (st == ST_REF) || (st == ST_PASS) || (st == ST_DRAIN);
   assign res_clr = ((st == ST_COLLECT) && in_valid && (wptr == POS_LAST)) ||
                    ((st == ST_COLLECT) && in_valid && (taken == take_m1)) ||
                    (st == ST_ZPAD);

   ovs_result_track #(.FRAME(FRAME), .W(SMP_W)) u_res (
      .clk(clk), .rst_n(rst_n), .clr(res_clr), .count_en(res_en),
      .rs_valid(rs_valid), .rs_i(rs_i), .rs_q(rs_q), .done(res_done),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         trig_d   <= 1'b0;
         long_q   <= 1'b0;
         seg      <= '0;
         wptr     <= '0;
         idx      <= '0;
         taken    <= '0;
         ref_re_q <= '0;
         ref_im_q <= '0;
      end else begin
         trig_d <= trig;
         unique case (st)
            ST_IDLE: begin
               if (trig_rise) begin
                  long_q <= long_sel;
                  seg    <= '0;
                  wptr   <= '0;
                  idx    <= '0;
                  taken  <= '0;
                  st     <= ST_COLLECT;
               end
            end
            ST_COLLECT: begin
               if (in_valid) begin
                  wptr  <= wptr + 1'b1;
                  taken <= taken + 1'b1;
                  if (wptr == POS_LAST) begin
                     idx <= '0;
                     st  <= ST_REF;
                  end else if (taken == take_m1) begin
                     st  <= ST_ZPAD;
                  end
               end
            end
            ST_ZPAD: begin
               wptr <= wptr + 1'b1;
               if (wptr == POS_LAST) begin
                  idx <= '0;
                  st  <= ST_REF;
               end
            end
            ST_REF: begin
               if (mem_ready) begin
                  ref_re_q <= mem_re;
                  ref_im_q <= mem_im;
                  st       <= ST_PASS;
               end
            end
            ST_PASS: begin
               if (idx == POS_LAST) begin
                  st <= ST_DRAIN;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_REF;
               end
            end
            ST_DRAIN: begin
               if (res_done) st <= ST_DONE;
            end
            ST_DONE: begin
               idx <= '0;
               if (long_q && (seg != SEG_LAST)) st <= ST_CARRY;
               else                             st <= ST_IDLE;
            end
            ST_CARRY: begin
               if (idx == OVL_LAST) begin
                  idx  <= '0;
                  wptr <= OVL_START;
                  seg  <= seg + 1'b1;
                  st   <= ST_COLLECT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (st == ST_REF);
   assign mem_addr  = long_q ? {seg, idx} : {SEG_W'(0), idx};
   assign pr_valid  = (st == ST_PASS);
   assign pr_smp_i  = buf_ri;
   assign pr_smp_q  = buf_rq;
   assign pr_ref_re = ref_re_q;
   assign pr_ref_im = ref_im_q;
   assign seg_idx   = seg;
   assign status    = 4'(st);
endmodule

// File: rtl/ovs_segment_ctrl_chk.sv
module ovs_segment_ctrl_chk
   import ovs_pkg::*;
#(
   parameter int IN_W   = 18,
   parameter int SMP_W  = 16,
   parameter int SEG_W  = 2,
   parameter int REF_AW = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [IN_W-1:0]   in_i,
   input logic [IN_W-1:0]   in_q,
   input logic              trig,
   input logic              long_sel,
   input logic              mem_req,
   input logic [REF_AW-1:0] mem_addr,
   input logic              mem_ready,
   input logic [SMP_W-1:0]  mem_re,
   input logic [SMP_W-1:0]  mem_im,
   input logic              pr_valid,
   input logic [SMP_W-1:0]  pr_smp_i,
   input logic [SMP_W-1:0]  pr_smp_q,
   input logic [SMP_W-1:0]  pr_ref_re,
   input logic [SMP_W-1:0]  pr_ref_im,
   input logic              rs_valid,
   input logic [SMP_W-1:0]  rs_i,
   input logic [SMP_W-1:0]  rs_q,
   input logic              out_valid,
   input logic [SMP_W-1:0]  out_i,
   input logic [SMP_W-1:0]  out_q,
   input logic [SEG_W-1:0]  seg_idx,
   input logic [3:0]        status
);
   logic rs_counted;
   assign rs_counted = rs_valid && (status == ST_REF || status == ST_PASS || status == ST_DRAIN);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R7

   AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_IDLE) && !trig |=> status == ST_IDLE); // R2

   AST_PAIR_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      pr_valid |-> $past(mem_ready)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_IDLE) |-> !mem_req && !pr_valid); // R10

   AST_RESULT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      rs_counted |=> out_valid && out_i == $past(rs_i) && out_q == $past(rs_q)); // R9

   AST_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) == ST_CARRY) && (status == ST_COLLECT)
      |-> seg_idx == SEG_W'($past(seg_idx) + 1'b1)); // R6
endmodule

bind ovs_segment_ctrl ovs_segment_ctrl_chk #(
   .IN_W(IN_W), .SMP_W(SMP_W), .SEG_W(SEG_W), .REF_AW(REF_AW)
) u_chk (.*);

// File: tb/tb_ovs_segment_ctrl.sv
module tb_ovs_segment_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        in_valid = 1'b0;
   logic [17:0] in_i = '0, in_q = '0;
   logic        trig = 1'b0, long_sel = 1'b0;
   logic        mem_req, mem_ready;
   logic [11:0] mem_addr;
   logic [15:0] mem_re, mem_im;
   logic        pr_valid;
   logic [15:0] pr_smp_i, pr_smp_q, pr_ref_re, pr_ref_im;
   logic        rs_valid;
   logic [15:0] rs_i, rs_q;
   logic        out_valid;
   logic [15:0] out_i, out_q;
   logic [1:0]  seg_idx;
   logic [3:0]  status;

   ovs_segment_ctrl dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .trig(trig), .long_sel(long_sel), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .mem_re(mem_re), .mem_im(mem_im),
      .pr_valid(pr_valid), .pr_smp_i(pr_smp_i), .pr_smp_q(pr_smp_q),
      .pr_ref_re(pr_ref_re), .pr_ref_im(pr_ref_im),
      .rs_valid(rs_valid), .rs_i(rs_i), .rs_q(rs_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
      .seg_idx(seg_idx), .status(status));

   // reference memory model: one-cycle ready, data encodes the address
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         mem_re    <= '0;
         mem_im    <= '0;
      end else begin
         mem_ready <= mem_req && !mem_ready;
         mem_re    <= {4'h0, mem_addr};
         mem_im    <= ~{4'h0, mem_addr};
      end
   end

   // processor stub: echoes sample I, and sample Q plus reference real, after 3 cycles
   logic [2:0]  sv;
   logic [15:0] si [3];
   logic [15:0] sq [3];
   always @(posedge clk) begin
      if (!rst_n) sv <= '0;
      else        sv <= {sv[1:0], pr_valid};
      si[0] <= pr_smp_i;            sq[0] <= pr_smp_q + pr_ref_re;
      si[1] <= si[0];               sq[1] <= sq[0];
      si[2] <= si[1];               sq[2] <= sq[1];
   end
   assign rs_valid = sv[2];
   assign rs_i     = si[2];
   assign rs_q     = sq[2];

   int n_checks = 0, n_fail = 0;
   int exp_i[$], exp_q[$];
   int cap_i [4096];
   int cap_q [4096];
   int cap_n = 0;
   bit [7:0] st_seen;
   bit [3:0] seg_seen;
   int addr_bad = 0;
   bit long_phase = 1'b0;

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   function automatic int conv(int x);
      int r;
      r = (x + 2) >>> 2;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   function automatic int wrap16(int v);
      logic [15:0] t;
      t = 16'(v);
      return int'($signed(t));
   endfunction

   function automatic int gen_i(bit lng, int n);
      if (lng) return ((n*37 + 11) % 262144) - 131072;
      case (n)
         0: return 131071;
         1: return -131072;
         2: return 1;
         3: return 2;
         4: return -2;
         5: return -3;
         6: return 131069;
         7: return 131070;
         default: return ((n*2741) % 262144) - 131072;
      endcase
   endfunction

   function automatic int gen_q(bit lng, int n);
      if (lng) return ((n*53 + 1000) % 262144) - 131072;
      return ((n*977 + 5) % 262144) - 131072;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         st_seen[status[2:0]] = 1'b1;
         if (mem_req && long_phase) begin
            seg_seen[seg_idx] = 1'b1;
            if (mem_addr[11:10] != seg_idx) addr_bad++;
         end
         if (out_valid) begin
            if (exp_i.size() == 0) begin
               chk(1'b0, "R9", "output with no expected item", cap_n, -1);
            end else begin
               int ei, eq;
               ei = exp_i.pop_front();
               eq = exp_q.pop_front();
               chk(int'($signed(out_i)) == ei, "R8", $sformatf("out_i item %0d", cap_n),
                   int'($signed(out_i)), ei);
               chk(int'($signed(out_q)) == eq, "R7", $sformatf("out_q item %0d", cap_n),
                   int'($signed(out_q)), eq);
            end
            if (cap_n < 4096) begin
               cap_i[cap_n] = int'($signed(out_i));
               cap_q[cap_n] = int'($signed(out_q));
            end
            cap_n++;
         end
      end
   end

   // driver: builds the expected frames, then triggers and feeds the pulse
   task automatic run_pulse(bit lng);
      int fr_i [1024];
      int fr_q [1024];
      int n, nseg, p, fed, tmo, target;
      n    = lng ? 3000 : 50;
      nseg = lng ? 4 : 1;
      p    = 0;
      for (int s = 0; s < nseg; s++) begin
         int start;
         start = 0;
         if (s > 0) begin
            for (int k = 0; k < 128; k++) begin
               fr_i[k] = fr_i[896 + k];
               fr_q[k] = fr_q[896 + k];
            end
            start = 128;
         end
         for (int k = start; k < 1024; k++) begin
            if (p < n) begin
               fr_i[k] = conv(gen_i(lng, p));
               fr_q[k] = conv(gen_q(lng, p));
               p++;
            end else begin
               fr_i[k] = 0;
               fr_q[k] = 0;
            end
         end
         for (int k = 0; k < 1024; k++) begin
            exp_i.push_back(fr_i[k]);
            exp_q.push_back(wrap16(fr_q[k] + (lng ? s*1024 + k : k)));
         end
      end
      cap_n      = 0;
      st_seen    = '0;
      seg_seen   = '0;
      addr_bad   = 0;
      long_phase = lng;
      target     = nseg * 1024;
      @(posedge clk); #1;
      trig = 1'b0; long_sel = lng;
      @(posedge clk); #1;
      trig = 1'b1;
      fed = 0;
      tmo = 0;
      while (!(fed == n && cap_n == target && status == 4'd0) && tmo < 60000) begin
         @(posedge clk); #1;
         tmo++;
         if (status == 4'd1 && fed < n) begin
            in_valid = 1'b1;
            in_i = 18'(gen_i(lng, fed));
            in_q = 18'(gen_q(lng, fed));
            fed++;
         end else begin
            in_valid = 1'b0;
         end
      end
      in_valid = 1'b0;
      chk(cap_n == target, "R9", "result count for pulse", cap_n, target);
      chk(exp_i.size() == 0, "R9", "expected items left over", exp_i.size(), 0);
      chk(status == 4'd0, "R9", "status after pulse", int'(status), 0);
      long_phase = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int moved, bad;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      chk(status == 4'd0, "R1", "status after reset", int'(status), 0);
      chk(seg_idx == 2'd0, "R1", "segment index after reset", int'(seg_idx), 0);
      chk(!mem_req && !pr_valid && !out_valid, "R1", "strobes after reset",
          int'({mem_req, pr_valid, out_valid}), 0);

      // samples while idle with trigger low must be ignored
      moved = 0;
      for (int c = 0; c < 20; c++) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         in_i = 18'h1ABCD;
         in_q = 18'h05555;
         if (status != 4'd0 || out_valid) moved++;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk(moved == 0, "R2", "idle cycles with activity", moved, 0);

      // short pulse
      run_pulse(1'b0);
      chk(cap_i[0] == 32767, "R3", "max input saturates", cap_i[0], 32767);
      chk(cap_i[1] == -32768, "R3", "min input", cap_i[1], -32768);
      chk(cap_i[2] == 0, "R3", "input 1 rounds", cap_i[2], 0);
      chk(cap_i[3] == 1, "R3", "input 2 rounds up", cap_i[3], 1);
      chk(cap_i[4] == 0, "R3", "input -2 rounds", cap_i[4], 0);
      chk(cap_i[5] == -1, "R3", "input -3 rounds", cap_i[5], -1);
      chk(cap_i[6] == 32767, "R3", "input 131069", cap_i[6], 32767);
      chk(cap_i[7] == 32767, "R3", "input 131070 saturates", cap_i[7], 32767);
      bad = 0;
      for (int k = 50; k < 1024; k++)
         if (cap_i[k] != 0 || cap_q[k] != k) bad++;
      chk(bad == 0, "R4", "short pulse zero-pad positions wrong", bad, 0);
      chk(st_seen[2] && st_seen[3] && st_seen[4] && st_seen[5] && st_seen[6] && !st_seen[7],
          "R10", "short pulse status codes seen", int'(st_seen), 8'h7F);

      // trigger held high after completion: no restart
      moved = 0;
      for (int c = 0; c < 30; c++) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         if (status != 4'd0) moved++;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk(moved == 0, "R2", "held trigger restarted", moved, 0);

      // long pulse
      run_pulse(1'b1);
      bad = 0;
      for (int s = 1; s < 4; s++)
         for (int k = 0; k < 128; k++)
            if (cap_i[s*1024 + k] != cap_i[(s-1)*1024 + 896 + k]) bad++;
      chk(bad == 0, "R6", "overlap positions differ from previous tail", bad, 0);
      bad = 0;
      for (int k = 312; k < 1024; k++)
         if (cap_i[3*1024 + k] != 0) bad++;
      chk(bad == 0, "R5", "last segment zero-pad positions nonzero", bad, 0);
      chk(cap_i[3*1024 + 311] == conv(gen_i(1'b1, 2999)), "R5", "last sample of pulse",
          cap_i[3*1024 + 311], conv(gen_i(1'b1, 2999)));
      chk(cap_i[1024 + 128] == conv(gen_i(1'b1, 1024)), "R5", "first new sample of segment 1",
          cap_i[1024 + 128], conv(gen_i(1'b1, 1024)));
      chk(seg_seen == 4'b1111, "R11", "segment indices seen", int'(seg_seen), 15);
      chk(addr_bad == 0, "R7", "address segment field mismatches", addr_bad, 0);
      chk(st_seen[7], "R10", "overlap copy status seen", int'(st_seen), 8'hFF);

      finish_run();
   end
endmodule